// File: doc/BRIEF.md
# Ethernet Transmit Bid Controller

This block manages the hand-off of one outgoing frame from a host register port into a single-frame transmit buffer of a 10 Mb/s Ethernet controller. The host first writes a command word, which selects the early-start threshold and the CRC and padding options. It then writes the frame length, which places a bid for buffer space. The bid is granted at once when the buffer is free. If the previous frame is still on the wire, the grant is deferred until the transmitter reports completion, and a one-cycle ready event is raised at that point.

Once the bid is granted, the host pushes the frame as 16-bit words, low byte first. The block turns these into buffer writes at consecutive word addresses and counts the bytes held. When the count first reaches the selected threshold, it sends a single-cycle start pulse to the transmitter. When the transmitter reports that the frame is finished, the block posts a completion event word that carries the OK flag and the collision count.

A command write with the discard bit set abandons a pending bid. Oversized bids, zero-length bids and bids made while another frame is pending are refused.

Top module: `tx_bid_top`

## Requirements
- R1: After reset, rdyNow, rdyEvent, bufWrEn, txStart and txEvValid are 0, and txLen, txNoCrc and txNoPad are 0.
- R2: A length write of 1..1518 while no bid is pending and no frame is in flight sets rdyNow in the next cycle. From that cycle, txLen shows the length and txNoCrc/txNoPad show bits 12/13 of the last command word written before the bid.
- R3: A length write of 0, or greater than 1518, is refused and leaves rdyNow at 0. A length write while a bid is pending (waiting or granted) is refused and leaves the pending frame, including txLen, unchanged.
- R4: A bid accepted while a started frame is still in flight holds rdyNow at 0. The cycle after macDone, rdyNow rises and rdyEvent pulses for exactly one cycle.
- R5: A data write while rdyNow is 0 is ignored and gives no buffer write. While rdyNow is 1, the next cycle carries bufWrEn=1 with bufData equal to the written word and bufAddr counting from 0 up by one per word.
- R6: The number of words accepted for a frame of length L is ceil(L/2). rdyNow falls in the cycle after the last word is written.
- R7: Command bits 7:6 pick the start threshold: 00 = 5 bytes, 01 = 381, 10 = 1021, 11 = whole frame. txStart pulses for one cycle, once per frame. It is due the cycle after the word that brings the byte count (min(2*words, L)) to min(threshold, L).
- R8: A command write with bit 8 set while a bid is pending discards it. rdyNow is 0 in the next cycle, no start is issued for it, and later data writes are ignored.
- R9: macDone while a started frame is in flight gives txEvValid for one cycle in the next cycle. txEvWord then has bit 8 equal to macOk, bits 14:11 equal to macColl, and all other bits 0. macDone while no frame is in flight is ignored.
- R10: A command write without bit 8 while a bid is pending does not change txNoCrc, txNoPad or the threshold of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWrEn | input | 1 | Command word write strobe |
| cmdIn | input | 16 | Command word (7:6 threshold, 8 discard, 12 no CRC, 13 no pad) |
| lenWrEn | input | 1 | Length write strobe, places a bid |
| lenIn | input | 16 | Frame length in bytes |
| dataWrEn | input | 1 | Frame data write strobe |
| dataIn | input | 16 | Frame data word, low byte first |
| macDone | input | 1 | Transmitter finished the in-flight frame |
| macOk | input | 1 | Transmitter outcome, valid with macDone |
| macColl | input | 4 | Collision count, valid with macDone |
| rdyNow | output | 1 | Space granted, host may write data |
| rdyEvent | output | 1 | One-cycle pulse on a deferred grant |
| bufWrEn | output | 1 | Buffer write enable |
| bufAddr | output | 10 | Buffer word address |
| bufData | output | 16 | Buffer write data |
| txStart | output | 1 | One-cycle start pulse to the transmitter |
| txLen | output | 11 | Length of the granted frame |
| txNoCrc | output | 1 | Frame sent without appended CRC |
| txNoPad | output | 1 | Short frame sent without padding |
| txEvValid | output | 1 | Completion event strobe |
| txEvWord | output | 16 | Completion event word |

## Verification
Every output of this block is registered, so each result is due in the cycle after the clock edge that sees its stimulus. A granted bid shows on rdyNow, a data word shows on bufWrEn/bufAddr/bufData, a threshold crossing shows on txStart, and macDone shows on txEvValid and, if a bid is waiting, on rdyNow with rdyEvent. The bench drives inputs on the falling edge. Its reference model advances on the rising edge from the same inputs, and every output is compared with the model on the following falling edge. Directed checks placed right after each stimulus confirm the specific values the requirements call for.

// File: rtl/tx_bid_pkg.sv
package tx_bid_pkg;

  // Bit positions that the host and the transmitter decode
  localparam int THR_LO     = 6;
  localparam int FORCE_BIT  = 8;
  localparam int NOCRC_BIT  = 12;
  localparam int NOPAD_BIT  = 13;
  localparam int EV_OK_BIT  = 8;
  localparam int EV_COLL_LO = 11;
  localparam int COLL_W     = 4;
  localparam int WORD_W     = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_FILL = 2'd2
  } bidState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic acceptBid;
    logic writeWord;
    logic postEvent;
  } dpStrobe_t;

endpackage

// File: rtl/tx_bid_dp.sv
module tx_bid_dp
  import tx_bid_pkg::*;
#(
  parameter int MAX_LEN = 1518,
  parameter int TH_A    = 5,
  parameter int TH_B    = 381,
  parameter int TH_C    = 1021,
  parameter int LEN_W   = 11,
  parameter int ADDR_W  = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic                 cmdWrEn,
  input  logic [WORD_W-1:0]    cmdIn,
  input  logic [WORD_W-1:0]    lenIn,
  input  logic [WORD_W-1:0]    dataIn,
  input  logic                 macOk,
  input  logic [COLL_W-1:0]    macColl,
  output logic                 lenValid,
  output logic                 nextHitsThr,
  output logic                 nextDone,
  output logic                 bufWrEn,
  output logic [ADDR_W-1:0]    bufAddr,
  output logic [WORD_W-1:0]    bufData,
  output logic [LEN_W-1:0]     txLen,
  output logic                 txNoCrc,
  output logic                 txNoPad,
  output logic                 txEvValid,
  output logic [WORD_W-1:0]    txEvWord
);

  localparam int EXT_W = LEN_W + 1;

  // Host-side command shadow (only the fields this block uses)
  logic [1:0]       hostThr;
  logic             hostNoCrc;
  logic             hostNoPad;
  // Fields latched for the granted frame
  logic [1:0]       frameThr;
  logic [LEN_W-1:0] byteCnt;

  logic [EXT_W-1:0] thrBytes;
  logic [EXT_W-1:0] lenExt;
  logic [EXT_W-1:0] effThr;
  logic [EXT_W-1:0] sumCnt;
  logic [EXT_W-1:0] nextCnt;
  logic [WORD_W-1:0] evWord;

  logic unusedCmdBits;
  assign unusedCmdBits = ^{cmdIn[WORD_W-1:NOPAD_BIT+1], cmdIn[NOCRC_BIT-1:THR_LO+2],
                           cmdIn[THR_LO-1:0]};

  assign lenValid = (lenIn != '0) && (lenIn <= WORD_W'(MAX_LEN));

  always_comb begin
    case (frameThr)
      2'd0:    thrBytes = EXT_W'(TH_A);
      2'd1:    thrBytes = EXT_W'(TH_B);
      2'd2:    thrBytes = EXT_W'(TH_C);
      default: thrBytes = {1'b0, txLen};
    endcase
  end

  assign lenExt      = {1'b0, txLen};
  assign effThr      = (thrBytes < lenExt) ? thrBytes : lenExt;
  assign sumCnt      = {1'b0, byteCnt} + EXT_W'(2);
  assign nextCnt     = (sumCnt > lenExt) ? lenExt : sumCnt;
  assign nextHitsThr = (nextCnt >= effThr);
  assign nextDone    = (nextCnt >= lenExt);

  always_comb begin
    evWord                          = '0;
    evWord[EV_OK_BIT]               = macOk;
    evWord[EV_COLL_LO +: COLL_W]    = macColl;
  end

  // Command shadow
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostThr   <= '0;
      hostNoCrc <= 1'b0;
      hostNoPad <= 1'b0;
    end else if (cmdWrEn) begin
      hostThr   <= cmdIn[THR_LO +: 2];
      hostNoCrc <= cmdIn[NOCRC_BIT];
      hostNoPad <= cmdIn[NOPAD_BIT];
    end
  end

  // Frame registers and byte counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameThr <= '0;
      txLen    <= '0;
      txNoCrc  <= 1'b0;
      txNoPad  <= 1'b0;
      byteCnt  <= '0;
    end else if (strobe.acceptBid) begin
      frameThr <= hostThr;
      txLen    <= lenIn[LEN_W-1:0];
      txNoCrc  <= hostNoCrc;
      txNoPad  <= hostNoPad;
      byteCnt  <= '0;
    end else if (strobe.writeWord) begin
      byteCnt  <= nextCnt[LEN_W-1:0];
    end
  end

  // Buffer write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufWrEn <= 1'b0;
      bufAddr <= '0;
      bufData <= '0;
    end else begin
      bufWrEn <= strobe.writeWord;
      if (strobe.writeWord) begin
        bufAddr <= ADDR_W'(byteCnt >> 1);
        bufData <= dataIn;
      end
    end
  end

  // Completion event
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEvValid <= 1'b0;
      txEvWord  <= '0;
    end else begin
      txEvValid <= strobe.postEvent;
      if (strobe.postEvent) txEvWord <= evWord;
    end
  end

endmodule

// File: rtl/tx_bid_ctrl.sv
module tx_bid_ctrl
  import tx_bid_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdWrEn,
  input  logic      forceBit,
  input  logic      lenWrEn,
  input  logic      dataWrEn,
  input  logic      macDone,
  input  logic      lenValid,
  input  logic      nextHitsThr,
  input  logic      nextDone,
  output dpStrobe_t strobe,
  output logic      rdyNow,
  output logic      rdyEvent,
  output logic      txStart
);

  bidState_t state, stateNext;
  logic inFlight;
  logic started;
  logic doneSeen;
  logic abortReq;
  logic acceptBid;
  logic writeWord;
  logic fireStart;
  logic lateGrant;

  assign doneSeen  = macDone && inFlight;
  assign abortReq  = cmdWrEn && forceBit && (state != ST_IDLE);
  assign acceptBid = !abortReq && lenWrEn && lenValid && (state == ST_IDLE);
  assign writeWord = !abortReq && dataWrEn && (state == ST_FILL);
  assign fireStart = writeWord && !started && nextHitsThr;
  assign lateGrant = !abortReq && (state == ST_WAIT) && doneSeen;

  assign strobe.acceptBid = acceptBid;
  assign strobe.writeWord = writeWord;
  assign strobe.postEvent = doneSeen;

  assign rdyNow = (state == ST_FILL);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (acceptBid) stateNext = (inFlight && !macDone) ? ST_WAIT : ST_FILL;
      ST_WAIT: begin
        if (abortReq)      stateNext = ST_IDLE;
        else if (doneSeen) stateNext = ST_FILL;
      end
      ST_FILL: begin
        if (abortReq)                   stateNext = ST_IDLE;
        else if (writeWord && nextDone) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      inFlight <= 1'b0;
      started  <= 1'b0;
      rdyEvent <= 1'b0;
      txStart  <= 1'b0;
    end else begin
      state    <= stateNext;
      rdyEvent <= lateGrant;
      txStart  <= fireStart;
      if (acceptBid)      started <= 1'b0;
      else if (fireStart) started <= 1'b1;
      if (fireStart)      inFlight <= 1'b1;
      else if (doneSeen)  inFlight <= 1'b0;
    end
  end

endmodule

// File: rtl/tx_bid_top.sv
module tx_bid_top
  import tx_bid_pkg::*;
#(
  parameter int MAX_LEN = 1518,
  parameter int TH_A    = 5,
  parameter int TH_B    = 381,
  parameter int TH_C    = 1021,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int ADDR_W = $clog2((MAX_LEN + 1) / 2)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdWrEn,
  input  logic [15:0]          cmdIn,
  input  logic                 lenWrEn,
  input  logic [15:0]          lenIn,
  input  logic                 dataWrEn,
  input  logic [15:0]          dataIn,
  input  logic                 macDone,
  input  logic                 macOk,
  input  logic [3:0]           macColl,
  output logic                 rdyNow,
  output logic                 rdyEvent,
  output logic                 bufWrEn,
  output logic [ADDR_W-1:0]    bufAddr,
  output logic [15:0]          bufData,
  output logic                 txStart,
  output logic [LEN_W-1:0]     txLen,
  output logic                 txNoCrc,
  output logic                 txNoPad,
  output logic                 txEvValid,
  output logic [15:0]          txEvWord
);

  dpStrobe_t strobe;
  logic lenValid;
  logic nextHitsThr;
  logic nextDone;

  tx_bid_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdWrEn    (cmdWrEn),
    .forceBit   (cmdIn[FORCE_BIT]),
    .lenWrEn    (lenWrEn),
    .dataWrEn   (dataWrEn),
    .macDone    (macDone),
    .lenValid   (lenValid),
    .nextHitsThr(nextHitsThr),
    .nextDone   (nextDone),
    .strobe     (strobe),
    .rdyNow     (rdyNow),
    .rdyEvent   (rdyEvent),
    .txStart    (txStart)
  );

  tx_bid_dp #(
    .MAX_LEN(MAX_LEN), .TH_A(TH_A), .TH_B(TH_B), .TH_C(TH_C),
    .LEN_W(LEN_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmdWrEn    (cmdWrEn),
    .cmdIn      (cmdIn),
    .lenIn      (lenIn),
    .dataIn     (dataIn),
    .macOk      (macOk),
    .macColl    (macColl),
    .lenValid   (lenValid),
    .nextHitsThr(nextHitsThr),
    .nextDone   (nextDone),
    .bufWrEn    (bufWrEn),
    .bufAddr    (bufAddr),
    .bufData    (bufData),
    .txLen      (txLen),
    .txNoCrc    (txNoCrc),
    .txNoPad    (txNoPad),
    .txEvValid  (txEvValid),
    .txEvWord   (txEvWord)
  );

endmodule

// File: rtl/tx_bid_chk.sv
module tx_bid_chk #(
  parameter int MAX_LEN = 1518,
  parameter int LEN_W   = 11,
  parameter int ADDR_W  = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdWrEn,
  input logic [15:0]       cmdIn,
  input logic              lenWrEn,
  input logic [15:0]       lenIn,
  input logic              dataWrEn,
  input logic              macDone,
  input logic              macOk,
  input logic [3:0]        macColl,
  input logic              rdyNow,
  input logic              rdyEvent,
  input logic              bufWrEn,
  input logic [ADDR_W-1:0] bufAddr,
  input logic              txStart,
  input logic              txEvValid,
  input logic [15:0]       txEvWord
);

  localparam int WORDS = (MAX_LEN + 1) / 2;

  AST_REFUSE_OVERSIZE: assert property (@(posedge clk) disable iff (!rstN)
    (lenWrEn && (lenIn > 16'(MAX_LEN)) && !rdyNow && !macDone) |=> !rdyNow); // R3

  AST_LATE_GRANT_READY: assert property (@(posedge clk) disable iff (!rstN)
    rdyEvent |-> rdyNow); // R4

  AST_WRITE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> ($past(rdyNow) && $past(dataWrEn))); // R5

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> (int'(bufAddr) < WORDS)); // R6

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !txStart); // R7

  AST_FORCE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrEn && cmdIn[8] && !lenWrEn) |=> !rdyNow); // R8

  AST_EVENT_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    txEvValid |-> $past(macDone)); // R9

  AST_EVENT_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    txEvValid |-> ((txEvWord[8] == $past(macOk)) && (txEvWord[14:11] == $past(macColl)))); // R9

endmodule

bind tx_bid_top tx_bid_chk #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdIn(cmdIn), .lenWrEn(lenWrEn),
  .lenIn(lenIn), .dataWrEn(dataWrEn), .macDone(macDone), .macOk(macOk),
  .macColl(macColl), .rdyNow(rdyNow), .rdyEvent(rdyEvent), .bufWrEn(bufWrEn),
  .bufAddr(bufAddr), .txStart(txStart), .txEvValid(txEvValid), .txEvWord(txEvWord)
);

// File: tb/sim_tx_bid_top.sv
`timescale 1ns/1ps
module sim_tx_bid_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWrEn = 1'b0, lenWrEn = 1'b0, dataWrEn = 1'b0, macDone = 1'b0, macOk = 1'b0;
  logic [15:0] cmdIn = '0, lenIn = '0, dataIn = '0;
  logic [3:0] macColl = '0;
  logic rdyNow, rdyEvent, bufWrEn, txStart, txNoCrc, txNoPad, txEvValid;
  logic [9:0] bufAddr;
  logic [15:0] bufData, txEvWord;
  logic [10:0] txLen;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;
  string phase = "R1";

  always #4 clk = ~clk; // 125 MHz

  tx_bid_top u0 (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdIn(cmdIn), .lenWrEn(lenWrEn),
    .lenIn(lenIn), .dataWrEn(dataWrEn), .dataIn(dataIn), .macDone(macDone),
    .macOk(macOk), .macColl(macColl), .rdyNow(rdyNow), .rdyEvent(rdyEvent),
    .bufWrEn(bufWrEn), .bufAddr(bufAddr), .bufData(bufData), .txStart(txStart),
    .txLen(txLen), .txNoCrc(txNoCrc), .txNoPad(txNoPad), .txEvValid(txEvValid),
    .txEvWord(txEvWord)
  );

  // ---------------- behavioural reference model ----------------
  int mSt, mInFl, mStarted, mCnt, mLen, mThr, mNoCrc, mNoPad;
  int hThr, hNoCrc, hNoPad;
  int mRdyEv, mBufWe, mAddr, mData, mStart, mEvV, mEvW;

  function automatic int thrOf(int code, int len);
    int t;
    case (code)
      0: t = 5;
      1: t = 381;
      2: t = 1021;
      default: t = len;
    endcase
    return (t < len) ? t : len;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSt = 0; mInFl = 0; mStarted = 0; mCnt = 0; mLen = 0; mThr = 0;
      mNoCrc = 0; mNoPad = 0; hThr = 0; hNoCrc = 0; hNoPad = 0;
      mRdyEv = 0; mBufWe = 0; mAddr = 0; mData = 0; mStart = 0; mEvV = 0; mEvW = 0;
    end else begin
      int dn, ab, nc;
      dn = (macDone && mInFl != 0) ? 1 : 0;
      ab = (cmdWrEn && cmdIn[8] && mSt != 0) ? 1 : 0;
      mRdyEv = 0; mBufWe = 0; mStart = 0; mEvV = 0;
      if (dn != 0) begin
        mEvV = 1;
        mEvW = (int'(macColl) << 11) | (int'(macOk) << 8);
      end
      if (ab != 0) mSt = 0;
      else if (mSt == 0) begin
        if (lenWrEn && lenIn >= 1 && lenIn <= 1518) begin
          mLen = lenIn; mThr = hThr; mNoCrc = hNoCrc; mNoPad = hNoPad;
          mCnt = 0; mStarted = 0;
          mSt = (mInFl != 0 && dn == 0) ? 1 : 2;
        end
      end else if (mSt == 1) begin
        if (dn != 0) begin mSt = 2; mRdyEv = 1; end
      end else if (dataWrEn) begin
        mBufWe = 1; mAddr = mCnt / 2; mData = dataIn;
        nc = (mCnt + 2 > mLen) ? mLen : mCnt + 2;
        if (mStarted == 0 && nc >= thrOf(mThr, mLen)) begin mStart = 1; mStarted = 1; end
        mCnt = nc;
        if (nc >= mLen) mSt = 0;
      end
      if (mStart != 0) mInFl = 1;
      else if (dn != 0) mInFl = 0;
      if (cmdWrEn) begin hThr = cmdIn[7:6]; hNoCrc = cmdIn[12]; hNoPad = cmdIn[13]; end
    end
  end

  task automatic cmp(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s (phase %s) at cycle %0d: actual=%0d expected=%0d",
               req, what, phase, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN && !finished) begin
      cmp("R2", "rdyNow", int'(rdyNow), (mSt == 2) ? 1 : 0);
      cmp("R4", "rdyEvent", int'(rdyEvent), mRdyEv);
      cmp("R5", "bufWrEn", int'(bufWrEn), mBufWe);
      if (mBufWe != 0) begin
        cmp("R5", "bufAddr", int'(bufAddr), mAddr);
        cmp("R5", "bufData", int'(bufData), mData);
      end
      cmp("R7", "txStart", int'(txStart), mStart);
      cmp("R9", "txEvValid", int'(txEvValid), mEvV);
      if (mEvV != 0) cmp("R9", "txEvWord", int'(txEvWord), mEvW);
      cmp("R10", "txLen", int'(txLen), mLen);
      cmp("R10", "txNoCrc", int'(txNoCrc), mNoCrc);
      cmp("R10", "txNoPad", int'(txNoPad), mNoPad);
    end
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired (phase %s) actual=%0d expected=0", phase, cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wrCmd(logic [15:0] v);
    @(negedge clk); cmdWrEn = 1; cmdIn = v;
    @(negedge clk); cmdWrEn = 0;
  endtask

  task automatic wrLen(logic [15:0] v);
    @(negedge clk); lenWrEn = 1; lenIn = v;
    @(negedge clk); lenWrEn = 0;
  endtask

  task automatic wrWords(int n, int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); dataWrEn = 1; dataIn = 16'(base + i * 7);
    end
    @(negedge clk); dataWrEn = 0;
  endtask

  task automatic pulseDone(logic ok, logic [3:0] coll);
    @(negedge clk); macDone = 1; macOk = ok; macColl = coll;
    @(negedge clk); macDone = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    cmp("R1", "rdyNow reset", int'(rdyNow), 0);
    cmp("R1", "bufWrEn reset", int'(bufWrEn), 0);
    cmp("R1", "txStart reset", int'(txStart), 0);
    cmp("R1", "txEvValid reset", int'(txEvValid), 0);
    cmp("R1", "txLen reset", int'(txLen), 0);
    rstN = 1;
    idle(2);

    // R5: data while not granted is ignored
    phase = "R5";
    @(negedge clk); dataWrEn = 1; dataIn = 16'h1234;
    @(negedge clk); dataWrEn = 0;
    cmp("R5", "ignored write", int'(bufWrEn), 0);

    // R2/R7: threshold 5 bytes, no CRC, len 10
    phase = "R2";
    wrCmd(16'h1000);
    wrLen(16'd10);
    cmp("R2", "rdyNow granted", int'(rdyNow), 1);
    cmp("R2", "txLen", int'(txLen), 10);
    cmp("R2", "txNoCrc", int'(txNoCrc), 1);
    phase = "R7";
    wrWords(5, 16'hA000);
    cmp("R6", "rdyNow after 5 words", int'(rdyNow), 0);

    // R4: deferred grant, whole-frame threshold, odd length 7, no pad
    phase = "R4";
    wrCmd(16'h20C0);
    wrLen(16'd7);
    cmp("R4", "rdyNow deferred", int'(rdyNow), 0);
    idle(3);
    pulseDone(1'b1, 4'd3);
    cmp("R4", "rdyNow late", int'(rdyNow), 1);
    cmp("R4", "rdyEvent", int'(rdyEvent), 1);
    cmp("R9", "txEvWord", int'(txEvWord), 16'h1900);
    phase = "R6";
    wrWords(4, 16'hB100);
    cmp("R6", "rdyNow after ceil(7/2)", int'(rdyNow), 0);

    // R9: completion with failure, then a stray done
    phase = "R9";
    pulseDone(1'b0, 4'd15);
    cmp("R9", "txEvWord fail", int'(txEvWord), 16'h7800);
    pulseDone(1'b1, 4'd1);
    cmp("R9", "stray done ignored", int'(txEvValid), 0);

    // R3: refused bids
    phase = "R3";
    wrCmd(16'h0040);
    wrLen(16'd1519);
    cmp("R3", "oversize refused", int'(rdyNow), 0);
    wrLen(16'd0);
    cmp("R3", "zero refused", int'(rdyNow), 0);
    wrLen(16'd1518);
    cmp("R3", "max accepted", int'(rdyNow), 1);
    wrLen(16'd20);
    cmp("R3", "second bid refused", int'(txLen), 1518);
    phase = "R7";
    wrWords(759, 16'h0100);
    cmp("R6", "rdyNow after 759 words", int'(rdyNow), 0);
    pulseDone(1'b1, 4'd0);

    // R8: discard a pending bid
    phase = "R8";
    wrCmd(16'h0080);
    wrLen(16'd600);
    wrWords(3, 16'hC000);
    wrCmd(16'h0180);
    cmp("R8", "rdyNow after discard", int'(rdyNow), 0);
    wrWords(2, 16'hC100);
    cmp("R8", "data after discard", int'(bufWrEn), 0);
    wrCmd(16'h0080);
    wrLen(16'd600);
    phase = "R7";
    wrWords(300, 16'hD000);
    pulseDone(1'b1, 4'd2);

    // R10: command rewrite during a pending frame, threshold 1021 with len 1518
    phase = "R10";
    wrCmd(16'h0080);
    wrLen(16'd1518);
    wrCmd(16'h30C0);
    cmp("R10", "txNoCrc held", int'(txNoCrc), 0);
    cmp("R10", "txNoPad held", int'(txNoPad), 0);
    phase = "R7";
    wrWords(759, 16'hE000);
    pulseDone(1'b1, 4'd5);
    idle(4);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule